// File: doc/BRIEF.md
# Dibit Ethernet Frame Transmitter

This block sends one Ethernet frame on a two-bit reduced media interface. The interface has a transmit enable and a two-bit data bus, and it runs at the reference clock rate. A caller raises a one-cycle start pulse. With the pulse it gives an offset and a length, which locate the payload in an external byte buffer. The block reads that buffer through a synchronous read port with one cycle of latency. The caller may clear the offset and length in the very next cycle, because the block captures them.

The block first sends the preamble and the start delimiter. It then streams the payload from the buffer, and the read address wraps at the end of the buffer. A short payload is extended with zero bytes up to the minimum frame body. The block then appends a CRC-32 frame check sequence, computed over the payload and the padding. Every byte leaves as four two-bit groups, and a busy flag refuses new starts until the line has gone idle.

Top module: `eth_dibit_tx`

## Requirements
- R1: After reset, `txen_o` is 0, `txd_o` is 2'b00 and `busy_o` is 0.
- R2: A start pulse taken while `busy_o` is 0 makes `busy_o` 1 in the following cycle. `txen_o` rises one cycle after that. The offset and length are captured, so they may change right after the pulse.
- R3: A frame opens with seven 0x55 bytes and then one 0xD5 byte.
- R4: Each byte goes out as four dibits, with bits [1:0] first and bits [7:6] last. `txd_o[0]` carries the lower bit of each pair.
- R5: Payload byte i is read from buffer address (offset + i) mod 128. The read port returns data one cycle after the address.
- R6: A payload shorter than 60 bytes is followed by 0x00 bytes until 60 bytes have been sent. A payload of 60 bytes or more gets no padding.
- R7: Four check bytes follow the payload and padding, lowest byte first. The check is a reflected CRC-32 with polynomial 0xEDB88320, started at all ones and complemented at the end. Over the ASCII string "123456789" it gives 0xCBF43926.
- R8: `txen_o` stays high, without a gap, for exactly 4*(8 + max(len,60) + 4) cycles. While it is low, `txd_o` is 2'b00.
- R9: `busy_o` stays high until `txen_o` has dropped. A start pulse seen while `busy_o` is 1 is ignored and does not begin a frame.
- R10: A length of 0 produces a frame body of 60 zero bytes, followed by its check bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle frame start request |
| offset_i | input | 7 | Buffer address of the first payload byte |
| len_i | input | 8 | Payload length in bytes, 0 to 128 |
| mem_addr_o | output | 7 | Read address to the payload buffer |
| mem_data_i | input | 8 | Read data, one cycle after the address |
| txen_o | output | 1 | Transmit enable |
| txd_o | output | 2 | Transmit dibit, bit 0 is the lower bit |
| busy_o | output | 1 | Frame in progress, starts refused |

## Verification
A new start request can arrive in the same cycle as the last dibit of the previous frame. In that cycle `busy_o` is still high, but it will fall at the next edge. The bench provokes this by holding start high, with junk offsets and lengths, on every cycle while busy is high, up to and including that final cycle. It judges the outcome in two ways. The captured frame must match the original request byte for byte. The line must then stay idle, with no second frame, for a dozen cycles.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_PRE, PH_SFD, PH_DATA, PH_PAD, PH_FCS
  } phase_e;

  localparam logic [7:0]  PRE_BYTE   = 8'h55;
  localparam logic [7:0]  SFD_BYTE   = 8'hD5;
  localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED   = 32'hFFFFFFFF;

  // one byte through the reflected CRC, lsb first
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/eth_tx_crc.sv
module eth_tx_crc
  import eth_tx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] fcs_o
);
  logic [31:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_SEED;
    else if (init_i) crc_q <= CRC_SEED;
    else if (en_i)   crc_q <= crc_step(crc_q, byte_i);
  end

  assign fcs_o = ~crc_q;
endmodule

// File: rtl/eth_tx_ser.sv
module eth_tx_ser #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              vld_i,
  output logic              rdy_o,
  output logic              txen_o,
  output logic [1:0]        txd_o
);
  localparam int DIBITS = BYTE_W / 2;
  localparam int CNT_W  = $clog2(DIBITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIBITS - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;

  // a byte is accepted only on slot 0
  assign rdy_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      txen_o <= 1'b0;
      txd_o  <= 2'b00;
    end else if (cnt_q == '0) begin
      if (vld_i) begin
        txen_o <= 1'b1;
        txd_o  <= byte_i[1:0];
        sh_q   <= byte_i >> 2;
        cnt_q  <= CNT_W'(1);
      end else begin
        txen_o <= 1'b0;
        txd_o  <= 2'b00;
      end
    end else begin
      txd_o <= sh_q[1:0];
      sh_q  <= sh_q >> 2;
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/eth_tx_seq.sv
module eth_tx_seq
  import eth_tx_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int MIN_LEN = 60,
  parameter int PRE_LEN = 7,
  parameter int LEN_W   = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              rdy_i,
  input  logic [7:0]        mem_data_i,
  input  logic [31:0]       fcs_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        byte_o,
  output logic              vld_o,
  output logic              crc_init_o,
  output logic              crc_en_o,
  output logic              active_o
);
  localparam logic [LEN_W-1:0] MIN_L   = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] PRE_END = LEN_W'(PRE_LEN - 1);
  localparam logic [LEN_W-1:0] FCS_END = LEN_W'(3);

  phase_e            phase_q;
  logic [LEN_W-1:0]  cnt_q, len_q, nx;
  logic [ADDR_W-1:0] ptr_q;
  logic              go, take;

  assign nx       = cnt_q + LEN_W'(1);
  assign go       = start_i & ~busy_i;
  assign take     = rdy_i & vld_o;
  assign active_o = (phase_q != PH_IDLE);
  assign mem_addr_o = ptr_q;
  assign crc_init_o = go;
  assign crc_en_o   = take & ((phase_q == PH_DATA) | (phase_q == PH_PAD));

  always_comb begin
    byte_o = 8'h00;
    vld_o  = 1'b0;
    unique case (phase_q)
      PH_PRE:  begin byte_o = PRE_BYTE;   vld_o = 1'b1; end
      PH_SFD:  begin byte_o = SFD_BYTE;   vld_o = 1'b1; end
      PH_DATA: begin byte_o = mem_data_i; vld_o = 1'b1; end
      PH_PAD:  begin byte_o = 8'h00;      vld_o = 1'b1; end
      PH_FCS:  begin byte_o = 8'(fcs_i >> {cnt_q[1:0], 3'b000}); vld_o = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
      ptr_q   <= '0;
    end else if (go) begin
      phase_q <= PH_PRE;
      cnt_q   <= '0;
      len_q   <= len_i;
      ptr_q   <= offset_i;
    end else if (take) begin
      unique case (phase_q)
        PH_PRE: begin
          if (cnt_q == PRE_END) begin
            phase_q <= PH_SFD;
            cnt_q   <= '0;
          end else cnt_q <= nx;
        end
        PH_SFD: begin
          cnt_q   <= '0;
          phase_q <= (len_q == '0) ? PH_PAD : PH_DATA;
        end
        PH_DATA: begin
          ptr_q <= ptr_q + ADDR_W'(1);
          cnt_q <= nx;
          if (nx == len_q) begin
            if (nx < MIN_L) phase_q <= PH_PAD;
            else begin
              phase_q <= PH_FCS;
              cnt_q   <= '0;
            end
          end
        end
        PH_PAD: begin
          if (nx >= MIN_L) begin
            phase_q <= PH_FCS;
            cnt_q   <= '0;
          end else cnt_q <= nx;
        end
        PH_FCS: begin
          if (cnt_q == FCS_END) phase_q <= PH_IDLE;
          else cnt_q <= nx;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/eth_dibit_tx.sv
module eth_dibit_tx #(
  parameter int ADDR_W  = 7,
  parameter int MIN_LEN = 60,
  parameter int PRE_LEN = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [ADDR_W:0]   len_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_data_i,
  output logic              txen_o,
  output logic [1:0]        txd_o,
  output logic              busy_o
);
  localparam int LEN_W = ADDR_W + 1;

  logic [7:0]  byte_w;
  logic        vld_w, rdy_w, crc_init_w, crc_en_w, active_w;
  logic [31:0] fcs_w;

  // busy covers the serializer tail after the last byte handoff
  assign busy_o = active_w | txen_o;

  eth_tx_seq #(
    .ADDR_W(ADDR_W), .MIN_LEN(MIN_LEN), .PRE_LEN(PRE_LEN), .LEN_W(LEN_W)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(start_i), .busy_i(busy_o),
    .offset_i(offset_i), .len_i(len_i),
    .rdy_i(rdy_w), .mem_data_i(mem_data_i), .fcs_i(fcs_w),
    .mem_addr_o(mem_addr_o), .byte_o(byte_w), .vld_o(vld_w),
    .crc_init_o(crc_init_w), .crc_en_o(crc_en_w), .active_o(active_w)
  );

  eth_tx_crc u_crc (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .init_i(crc_init_w), .en_i(crc_en_w), .byte_i(byte_w), .fcs_o(fcs_w)
  );

  eth_tx_ser #(.BYTE_W(8)) u_ser (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .byte_i(byte_w), .vld_i(vld_w), .rdy_o(rdy_w),
    .txen_o(txen_o), .txd_o(txd_o)
  );
endmodule

// File: rtl/eth_dibit_tx_chk.sv
module eth_dibit_tx_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              txen_o,
  input logic [1:0]        txd_o,
  input logic              busy_o
);
  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!txen_o && txd_o == 2'b00));

  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  p_txen_lead_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(txen_o) |-> $past(busy_o));

  p_first_dibit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(txen_o) |-> txd_o == 2'b01);

  p_drop_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(txen_o) |-> !busy_o);

  p_addr_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(mem_addr_o));
endmodule

bind eth_dibit_tx eth_dibit_tx_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mem_addr_o(mem_addr_o),
  .txen_o(txen_o), .txd_o(txd_o), .busy_o(busy_o)
);

// File: tb/eth_dibit_tx_bench.sv
module eth_dibit_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [6:0] offset = '0;
  logic [7:0] len = '0;
  logic [6:0] addr;
  logic [7:0] rd_q;
  logic       txen, busy;
  logic [1:0] txd;

  always #10 clk = ~clk;

  eth_dibit_tx u_eth_dibit_tx (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .offset_i(offset), .len_i(len),
    .mem_addr_o(addr), .mem_data_i(rd_q), .txen_o(txen), .txd_o(txd), .busy_o(busy)
  );

  logic [7:0] mem [0:127];
  always @(posedge clk) rd_q <= mem[addr];

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [1:0] cap [0:2047];
  int cap_n = 0, first_cyc = 0, rises = 0;
  logic prev_en = 1'b0;
  always @(negedge clk) begin
    if (txen) begin
      if (cap_n == 0) first_cyc = cyc;
      if (!prev_en) rises++;
      if (cap_n < 2048) cap[cap_n] = txd;
      cap_n++;
    end
    prev_en = txen;
  end

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] exp_b [0:255];
  int exp_n;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r = c ^ {24'h0, d};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  function automatic logic [7:0] cap_byte(input int k);
    return {cap[4*k+3], cap[4*k+2], cap[4*k+1], cap[4*k]};
  endfunction

  // first mismatching byte index in [a,b), or -1
  function automatic int region_bad(input int a, input int b);
    for (int k = a; k < b; k++) begin
      if (4*k+3 >= cap_n || cap_byte(k) !== exp_b[k]) return k;
    end
    return -1;
  endfunction

  task automatic send(input int off, input int ln, input bit hammer);
    logic [31:0] c;
    int body, s, bad, n0;
    string preq;
    exp_n = 0;
    for (int k = 0; k < 7; k++) exp_b[exp_n++] = 8'h55;
    exp_b[exp_n++] = 8'hD5;
    for (int k = 0; k < ln; k++) exp_b[exp_n++] = mem[(off + k) % 128];
    for (int k = ln; k < 60; k++) exp_b[exp_n++] = 8'h00;
    body = exp_n - 8;
    c = 32'hFFFFFFFF;
    for (int k = 8; k < exp_n; k++) c = ref_crc_step(c, exp_b[k]);
    c = ~c;
    for (int k = 0; k < 4; k++) exp_b[exp_n++] = c[8*k +: 8];

    @(negedge clk);
    cap_n = 0; rises = 0;
    start = 1'b1; offset = 7'(off); len = 8'(ln); s = cyc;
    @(negedge clk);
    start = 1'b0; offset = '0; len = '0;
    check(busy === 1'b1, "R2 busy after start", busy, 1);
    for (int w = 0; w < 3000; w++) begin
      if (!busy) break;
      if (hammer) begin
        start = 1'b1; offset = 7'($urandom); len = 8'($urandom % 129);
      end
      @(negedge clk);
    end
    start = 1'b0; offset = '0; len = '0;
    check(busy === 1'b0, "R9 busy released", busy, 0);
    check(first_cyc == s + 2, "R2 txen latency", first_cyc - s, 2);
    check(rises == 1, "R8 txen contiguous", rises, 1);
    check(cap_n == 4 * exp_n, "R8 dibit count", cap_n, 4 * exp_n);
    check(cap[0] == 2'b01, "R4 first dibit lsb pair", cap[0], 1);
    bad = region_bad(0, 8);
    check(bad < 0, "R3 preamble/sfd", bad < 0 ? 0 : cap_byte(bad), bad < 0 ? 0 : exp_b[bad]);
    if (ln > 0) begin
      bad = region_bad(8, 8 + ln);
      check(bad < 0, "R5 payload", bad < 0 ? 0 : cap_byte(bad), bad < 0 ? 0 : exp_b[bad]);
    end
    if (ln < 60) begin
      preq = (ln == 0) ? "R10 zero-length pad" : "R6 pad";
      bad = region_bad(8 + ln, 8 + body);
      check(bad < 0, preq, bad < 0 ? 0 : cap_byte(bad), bad < 0 ? 0 : exp_b[bad]);
    end
    bad = region_bad(8 + body, exp_n);
    check(bad < 0, "R7 fcs", bad < 0 ? 0 : cap_byte(bad), bad < 0 ? 0 : exp_b[bad]);
    n0 = cap_n;
    repeat (12) @(negedge clk);
    check(cap_n == n0 && !busy, "R9 no frame from ignored start", cap_n - n0, 0);
  endtask

  initial begin
    logic [31:0] c;
    string s9;
    void'($urandom(32'd4711));
    for (int k = 0; k < 128; k++) mem[k] = 8'($urandom);
    repeat (3) @(negedge clk);
    check(!txen && txd == 2'b00 && !busy, "R1 reset state", {txen, txd, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!txen && txd == 2'b00 && !busy, "R1 after release", {txen, txd, busy}, 0);

    s9 = "123456789";
    c = 32'hFFFFFFFF;
    for (int k = 0; k < 9; k++) c = ref_crc_step(c, s9[k]);
    check(~c == 32'hCBF43926, "R7 crc check value", ~c, 32'hCBF43926);

    send(120, 42, 1'b0);
    send(3, 0, 1'b0);
    send(10, 59, 1'b0);
    send(70, 60, 1'b1);
    send(127, 61, 1'b0);
    send(5, 128, 1'b1);
    for (int f = 0; f < 6; f++) begin
      int o, l;
      o = int'($urandom % 128);
      l = int'($urandom % 129);
      send(o, l, 1'($urandom % 2));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule